// File: doc/BRIEF.md
# Microwire Serial EEPROM Command Engine

This block is a hardware master for a Microwire serial EEPROM. A host gives it a command code, an address, write data and an organisation flag that selects 8-bit or 16-bit words, then pulses a start input. The engine raises chip select and shifts out a start bit, a two-bit opcode and the address, plus the data word for writes. It drives all of this most significant bit first, with the serial clock idling low. For a read it clocks the returned word back in. For commands that program the array it drops chip select, raises it again, and polls the device's data-out line until the device reports ready or a bounded number of checks runs out.

The four commands that share the 00 opcode (fill, erase all, enable writes, disable writes) carry a two-bit selector followed by zero padding, so their frame is as long as an addressed one. The address width is a parameter. It counts the bits used in 8-bit mode, and 16-bit mode uses one bit fewer. Further parameters set the number of system cycles in each serial clock phase and in each polling interval. The host sees a busy level and a one-cycle done pulse, which is valid together with the error bit and the read data. The top register drives states named IDLE, SEND_LO, SEND_HI, RECV_LO, RECV_HI, DESEL, POLL, FINISH and GUARD.

The state transitions are as follows:
- IDLE goes to SEND_LO when a valid start arrives.
- SEND_LO goes to SEND_HI after each low phase.
- SEND_HI goes back to SEND_LO for the next bit. After the last bit it goes to RECV_LO for a read, to DESEL for a programming command, and to FINISH otherwise.
- RECV_LO and RECV_HI alternate until the word is complete, then go to FINISH.
- DESEL goes to POLL after one phase.
- POLL goes to FINISH when the device is ready or the checks run out.
- FINISH goes to GUARD.
- GUARD goes to IDLE after one full serial clock period.

Top module: `mw_eeprom_master`

## Requirements
- R1: The command codes on `cmd_i` are 0 read, 1 write, 2 write-all, 3 erase, 4 erase-all, 5 enable writes and 6 disable writes. Every frame starts with a 1 bit and then a two-bit opcode: read 10, write 01, erase 11.
- R2: Write-all, erase-all, enable and disable send opcode 00 and then the selectors 01, 10, 11 and 00 respectively. After that come N-2 zero bits, where N is the address width in use, so the frame after the start bit is N+2 bits long.
- R3: Address bits follow the opcode MSB first. N is ADDR_W when `org16_i`=0 and ADDR_W-1 when `org16_i`=1, and in 16-bit mode the top address input bit is not sent.
- R4: Write and write-all append the data MSB first after the address field or padding. The data is `wdata_i[7:0]` (8 bits) when `org16_i`=0 and `wdata_i[15:0]` when `org16_i`=1.
- R5: `di_o` changes only while `sk_o` is low, and each high phase of `sk_o` lasts exactly CLK_DIV system cycles. `sk_o` is low whenever `cs_o` is low.
- R6: A read clocks in 8 or 16 bits after the address, sampling `dout_i` during each high phase and assembling MSB first. In 16-bit mode the first byte lands in `rdata_o[15:8]`, and in 8-bit mode `rdata_o[15:8]` is zero.
- R7: After the frame of a write, write-all, erase or erase-all, `cs_o` falls and rises once more. The engine then samples `dout_i` every POLL_CYCLES cycles, and a high sample ends the command with `err_o`=0.
- R8: If POLL_LIMIT samples in a row are low, the command ends with `err_o`=1 and `cs_o` low.
- R9: Read, enable and disable end with `err_o`=0, even right after a command that timed out.
- R10: After reset `cs_o`, `sk_o`, `busy_o` and `done_o` are low. `busy_o` is high from the cycle after an accepted start until the engine returns to idle. `done_o` is a single-cycle pulse.
- R11: A start while `busy_o` is high has no effect on the frame in progress and adds no done pulse. A start with code 7 is not accepted.
- R12: Between the done pulse of one command and the rise of `cs_o` for the next, at least 2×CLK_DIV cycles pass with `cs_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Command launch pulse |
| cmd_i | input | 3 | Command code |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 16 | Write data |
| org16_i | input | 1 | 1 selects 16-bit words |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Ready-poll timeout flag |
| rdata_o | output | 16 | Assembled read word |
| cs_o | output | 1 | Chip select to device |
| sk_o | output | 1 | Serial clock to device |
| di_o | output | 1 | Serial data to device |
| dout_i | input | 1 | Serial data from device |

## Verification
Every command code is tried in both organisations. Reads sweep the whole address space and the other commands use several address and data patterns, so a swapped opcode, a wrong pad length, a missing address-bit drop in 16-bit mode and a byte-order error each give a different captured frame or read word. The ready poll is tried with an early ready, a later ready and a device that never becomes ready, which separates the error and no-error paths. A read that follows a timeout shows that the error bit is cleared. Starts issued while busy and the unused code 7 show that unaccepted starts leave the bus untouched.

// File: rtl/mw_pkg.sv
package mw_pkg;

    typedef enum logic [2:0] {
        CMD_READ  = 3'd0,
        CMD_WRITE = 3'd1,
        CMD_WRALL = 3'd2,
        CMD_ERASE = 3'd3,
        CMD_ERALL = 3'd4,
        CMD_WEN   = 3'd5,
        CMD_WDIS  = 3'd6,
        CMD_NONE  = 3'd7
    } mw_cmd_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SEND_LO,
        ST_SEND_HI,
        ST_RECV_LO,
        ST_RECV_HI,
        ST_DESEL,
        ST_POLL,
        ST_FINISH,
        ST_GUARD
    } mw_state_e;

endpackage

// File: rtl/mw_tick.sv
module mw_tick #(
    parameter int DIV = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (clr_i)          cnt_q <= '0;
        else if (cnt_q == LAST)  cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = (cnt_q == LAST);

endmodule

// File: rtl/mw_frame.sv
module mw_frame
    import mw_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int FW     = 3 + ADDR_W + 16,
    parameter int LEN_W  = $clog2(FW + 1)
) (
    input  mw_cmd_e           cmd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [15:0]       wdata_i,
    input  logic              org16_i,
    output logic [FW-1:0]     frame_o,
    output logic [LEN_W-1:0]  out_len_o,
    output logic [LEN_W-1:0]  in_len_o
);
    int                na;
    int                dl;
    logic [ADDR_W-1:0] amask;
    logic [FW-1:0]     aval;
    logic [FW-1:0]     dval;

    always_comb begin
        na    = org16_i ? ADDR_W - 1 : ADDR_W;
        dl    = org16_i ? 16 : 8;
        amask = org16_i ? {1'b0, {(ADDR_W-1){1'b1}}} : {ADDR_W{1'b1}};
        aval  = FW'(addr_i & amask);
        dval  = org16_i ? FW'(wdata_i) : FW'(wdata_i[7:0]);
        frame_o   = '0;
        out_len_o = LEN_W'(3 + na);
        in_len_o  = '0;
        unique case (cmd_i)
            CMD_READ: begin
                frame_o  = (FW'(3'b110) << (FW - 3)) | (aval << (FW - 3 - na));
                in_len_o = LEN_W'(dl);
            end
            CMD_WRITE: begin
                frame_o   = (FW'(3'b101) << (FW - 3)) | (aval << (FW - 3 - na))
                          | (dval << (FW - 3 - na - dl));
                out_len_o = LEN_W'(3 + na + dl);
            end
            CMD_ERASE: frame_o = (FW'(3'b111) << (FW - 3)) | (aval << (FW - 3 - na));
            CMD_WRALL: begin
                frame_o   = (FW'(5'b10001) << (FW - 5)) | (dval << (FW - 3 - na - dl));
                out_len_o = LEN_W'(3 + na + dl);
            end
            CMD_ERALL: frame_o = FW'(5'b10010) << (FW - 5);
            CMD_WEN:   frame_o = FW'(5'b10011) << (FW - 5);
            CMD_WDIS:  frame_o = FW'(5'b10000) << (FW - 5);
            CMD_NONE:  frame_o = '0;
        endcase
    end

endmodule

// File: rtl/mw_eeprom_master.sv
module mw_eeprom_master
    import mw_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int CLK_DIV     = 100,
    parameter int POLL_CYCLES = 5000,
    parameter int POLL_LIMIT  = 220
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [2:0]        cmd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [15:0]       wdata_i,
    input  logic              org16_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [15:0]       rdata_o,
    output logic              cs_o,
    output logic              sk_o,
    output logic              di_o,
    input  logic              dout_i
);
    localparam int FW    = 3 + ADDR_W + 16;
    localparam int LEN_W = $clog2(FW + 1);
    localparam int PC_W  = (POLL_CYCLES > 1) ? $clog2(POLL_CYCLES) : 1;
    localparam int PL_W  = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;

    mw_state_e        state_q, state_d;
    mw_cmd_e          cmd_e, cmd_q;
    logic [FW-1:0]    frame_d, frame_q;
    logic [LEN_W-1:0] olen_d, olen_q, ilen_d, ilen_q, bitcnt_q;
    logic [PC_W-1:0]  pcnt_q;
    logic [PL_W-1:0]  checks_q;
    logic [15:0]      rdata_q;
    logic             err_q;
    logic             tick, launch, needs_poll, poll_due, last_out, last_in;

    assign cmd_e      = mw_cmd_e'(cmd_i);
    assign launch     = (state_q == ST_IDLE) && start_i && (cmd_e != CMD_NONE);
    assign needs_poll = (cmd_q == CMD_WRITE) || (cmd_q == CMD_WRALL) ||
                        (cmd_q == CMD_ERASE) || (cmd_q == CMD_ERALL);
    assign poll_due   = (pcnt_q == PC_W'(POLL_CYCLES - 1));
    assign last_out   = (bitcnt_q == olen_q - 1'b1);
    assign last_in    = (bitcnt_q == ilen_q - 1'b1);

    mw_frame #(.ADDR_W(ADDR_W), .FW(FW), .LEN_W(LEN_W)) u_frame (
        .cmd_i     (cmd_e),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .org16_i   (org16_i),
        .frame_o   (frame_d),
        .out_len_o (olen_d),
        .in_len_o  (ilen_d)
    );

    mw_tick #(.DIV(CLK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (state_d != state_q),
        .tick_o (tick)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (launch) state_d = ST_SEND_LO;
            ST_SEND_LO: if (tick) state_d = ST_SEND_HI;
            ST_SEND_HI: if (tick) begin
                if (!last_out)             state_d = ST_SEND_LO;
                else if (cmd_q == CMD_READ) state_d = ST_RECV_LO;
                else if (needs_poll)       state_d = ST_DESEL;
                else                       state_d = ST_FINISH;
            end
            ST_RECV_LO: if (tick) state_d = ST_RECV_HI;
            ST_RECV_HI: if (tick) state_d = last_in ? ST_FINISH : ST_RECV_LO;
            ST_DESEL:   if (tick) state_d = ST_POLL;
            ST_POLL:    if (poll_due && (dout_i || checks_q == PL_W'(POLL_LIMIT - 1)))
                            state_d = ST_FINISH;
            ST_FINISH:  state_d = ST_GUARD;
            ST_GUARD:   if (tick && bitcnt_q == LEN_W'(1)) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= CMD_NONE; frame_q <= '0; olen_q <= '0; ilen_q <= '0;
            bitcnt_q <= '0; pcnt_q <= '0; checks_q <= '0; rdata_q <= '0; err_q <= 1'b0;
        end else if (launch) begin
            cmd_q <= cmd_e; frame_q <= frame_d; olen_q <= olen_d; ilen_q <= ilen_d;
            bitcnt_q <= '0; pcnt_q <= '0; checks_q <= '0; rdata_q <= '0; err_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_SEND_HI: if (tick) begin
                    frame_q  <= frame_q << 1;
                    bitcnt_q <= last_out ? '0 : bitcnt_q + 1'b1;
                end
                ST_RECV_HI: if (tick) begin
                    rdata_q  <= {rdata_q[14:0], dout_i};
                    bitcnt_q <= last_in ? '0 : bitcnt_q + 1'b1;
                end
                ST_POLL: begin
                    if (poll_due) begin
                        pcnt_q <= '0;
                        if (!dout_i) begin
                            if (checks_q == PL_W'(POLL_LIMIT - 1)) err_q <= 1'b1;
                            else                                   checks_q <= checks_q + 1'b1;
                        end
                    end else begin
                        pcnt_q <= pcnt_q + 1'b1;
                    end
                end
                ST_GUARD: if (tick) bitcnt_q <= bitcnt_q + 1'b1;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        cs_o   = 1'b0;
        sk_o   = 1'b0;
        di_o   = 1'b0;
        busy_o = (state_q != ST_IDLE);
        done_o = 1'b0;
        unique case (state_q)
            ST_SEND_LO: begin cs_o = 1'b1; di_o = frame_q[FW-1]; end
            ST_SEND_HI: begin cs_o = 1'b1; sk_o = 1'b1; di_o = frame_q[FW-1]; end
            ST_RECV_LO: cs_o = 1'b1;
            ST_RECV_HI: begin cs_o = 1'b1; sk_o = 1'b1; end
            ST_POLL:    cs_o = 1'b1;
            ST_FINISH:  done_o = 1'b1;
            default: ;
        endcase
    end

    assign err_o   = err_q;
    assign rdata_o = rdata_q;

    AST_SK_NEEDS_CS:    assert property (@(posedge clk) disable iff (!rst_n) !cs_o |-> !sk_o); // R5
    AST_DI_HELD_SK_HI:  assert property (@(posedge clk) disable iff (!rst_n) (sk_o && $past(sk_o)) |-> $stable(di_o)); // R5
    AST_DONE_PULSE:     assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o); // R10
    AST_CMD_HELD_BUSY:  assert property (@(posedge clk) disable iff (!rst_n) (busy_o && $past(busy_o)) |-> $stable(cmd_q)); // R11
    AST_NO_ERR_NONPOLL: assert property (@(posedge clk) disable iff (!rst_n) (done_o && !needs_poll) |-> !err_o); // R9
    AST_POLL_BOUND:     assert property (@(posedge clk) disable iff (!rst_n) (state_q == ST_POLL) |-> (checks_q <= PL_W'(POLL_LIMIT - 1))); // R8
    AST_GUARD_CS_LOW:   assert property (@(posedge clk) disable iff (!rst_n) done_o |=> (!cs_o && busy_o)); // R12

endmodule

// File: tb/mw_eeprom_master_bench.sv
module mw_eeprom_master_bench;
    localparam int AW = 4, CD = 2, PC = 3, PL = 5;

    logic clk = 1'b0, rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          start = 1'b0, org16 = 1'b0, dout = 1'b1;
    logic [2:0]    cmd = '0;
    logic [AW-1:0] addr = '0;
    logic [15:0]   wdata = '0;
    logic          busy, done, err, cs, sk, di;
    logic [15:0]   rdata;

    mw_eeprom_master #(.ADDR_W(AW), .CLK_DIV(CD), .POLL_CYCLES(PC), .POLL_LIMIT(PL)) u_mw_eeprom_master (
        .clk(clk), .rst_n(rst_n), .start_i(start), .cmd_i(cmd), .addr_i(addr),
        .wdata_i(wdata), .org16_i(org16), .busy_o(busy), .done_o(done), .err_o(err),
        .rdata_o(rdata), .cs_o(cs), .sk_o(sk), .di_o(di), .dout_i(dout)
    );

    int n_tests = 0, n_fail = 0;

    // device model and monitors
    logic [63:0] cap = '0;
    int ncap = 0, rises = 0, hi_run = 0, bad_phase = 0, bad_di = 0;
    int ndone = 0, gap = 1000, last_gap = 1000, pcyc = 0;
    logic sk_prev = 1'b0, cs_prev = 1'b0, di_prev = 1'b0;
    bit armed = 1'b0;
    // command context
    int base_cap = 0, base_rise = 0, exp_len = 0, dl_cur = 8, ready_delay = 5;
    logic [63:0] exp_bits = '0;
    logic [15:0] rd_pat = '0;
    bit ctx_read = 1'b0, ctx_poll = 1'b0;

    always @(posedge clk) begin
        if (sk && !sk_prev && cs) begin
            int k;
            k = ncap - base_cap;
            if (ctx_read && k >= exp_len && k < exp_len + dl_cur)
                dout <= rd_pat[dl_cur - 1 - (k - exp_len)];
            cap  = {cap[62:0], di};
            ncap = ncap + 1;
        end
        if (cs && !cs_prev) begin
            rises    = rises + 1;
            last_gap = gap;
            if (ctx_poll && rises - base_rise == 2) begin
                dout <= 1'b0; armed = 1'b1; pcyc = 0;
            end
        end
        if (armed) begin
            pcyc = pcyc + 1;
            if (pcyc == ready_delay) dout <= 1'b1;
        end
        if (done) begin
            dout <= 1'b1; armed = 1'b0; ndone = ndone + 1; gap = 0;
        end else begin
            gap = gap + 1;
        end
        if (sk) hi_run = hi_run + 1;
        else begin
            if (sk_prev && hi_run != CD) bad_phase = bad_phase + 1;
            hi_run = 0;
        end
        if (sk && sk_prev && di != di_prev) bad_di = bad_di + 1;
        sk_prev = sk; cs_prev = cs; di_prev = di;
    end

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, expv);
        end
    endtask

    task automatic push(input logic [15:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            exp_bits = {exp_bits[62:0], v[i]};
            exp_len++;
        end
    endtask

    function automatic string tag_of(input int c);
        case (c)
            0:       return "R1 R3 read frame";
            3:       return "R1 R3 erase frame";
            1:       return "R4 write frame";
            2:       return "R2 R4 write-all frame";
            default: return "R2 extended frame";
        endcase
    endfunction

    task automatic run(input int c, input logic [AW-1:0] a, input logic [15:0] d, input bit o,
                       input logic [15:0] rp, input int rdly, input bit exp_err);
        int na, dl;
        logic [63:0] mask, got;
        na = o ? AW - 1 : AW;
        dl = o ? 16 : 8;
        exp_bits = '0; exp_len = 0;
        push(16'd1, 1);
        case (c)
            0: begin push(16'd2, 2); push(16'(a), na); end
            1: begin push(16'd1, 2); push(16'(a), na); push(d, dl); end
            2: begin push(16'd0, 2); push(16'd1, 2); push(16'd0, na - 2); push(d, dl); end
            3: begin push(16'd3, 2); push(16'(a), na); end
            4: begin push(16'd0, 2); push(16'd2, 2); push(16'd0, na - 2); end
            5: begin push(16'd0, 2); push(16'd3, 2); push(16'd0, na - 2); end
            default: begin push(16'd0, 2); push(16'd0, 2); push(16'd0, na - 2); end
        endcase
        @(negedge clk);
        ctx_read = (c == 0); ctx_poll = (c inside {1, 2, 3, 4});
        dl_cur = dl; rd_pat = rp; ready_delay = rdly;
        base_cap = ncap; base_rise = rises;
        cmd = 3'(c); addr = a; wdata = d; org16 = o; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy, "R10 busy after start", 64'(busy), 64'd1);
        while (!done) @(negedge clk);
        mask = (64'd1 << exp_len) - 64'd1;
        got  = ctx_read ? ((cap >> dl) & mask) : (cap & mask);
        chk(got == exp_bits && (ncap - base_cap) == exp_len + (ctx_read ? dl : 0),
            tag_of(c), got, exp_bits);
        if (ctx_read)
            chk(rdata == (o ? rp : {8'h00, rp[7:0]}), "R6 read word", 64'(rdata),
                64'(o ? rp : {8'h00, rp[7:0]}));
        chk(err == exp_err, ctx_poll ? "R7 R8 poll status" : "R9 no error", 64'(err), 64'(exp_err));
        chk((rises - base_rise) == (ctx_poll ? 2 : 1), "R7 chip select reselect",
            64'(rises - base_rise), 64'(ctx_poll ? 2 : 1));
        chk(last_gap >= 2 * CD, "R12 deselect gap", 64'(last_gap), 64'(2 * CD));
        @(negedge clk);
        chk(!done, "R10 done single cycle", 64'(done), 64'd0);
        while (busy) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!cs && !sk && !busy && !done, "R10 reset idle", {cs, sk, busy, done}, 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int o = 0; o < 2; o++)
            for (int c = 0; c < 7; c++)
                for (int a = 0; a < (1 << AW); a += ((c == 0) ? 1 : 5))
                    run(c, AW'(a), 16'h9A3C ^ 16'(a * 16'h0F0F), o[0],
                        16'hC35A ^ 16'(a * 16'h1357), 5, 1'b0);

        run(1, 4'h3, 16'h1234, 1'b0, 16'h0, 1000, 1'b1);   // R8 never ready
        run(0, 4'h6, 16'h0, 1'b1, 16'hBEEF, 5, 1'b0);      // R9 err cleared by read
        run(4, 4'h0, 16'h0, 1'b1, 16'h0, 1000, 1'b1);      // R8 erase-all timeout
        run(5, 4'h0, 16'h0, 1'b0, 16'h0, 5, 1'b0);         // R9 enable after timeout
        run(3, 4'hA, 16'h0, 1'b0, 16'h0, 8, 1'b0);         // R7 later ready
        run(2, 4'h0, 16'h5AA5, 1'b1, 16'h0, 2, 1'b0);      // R7 early ready

        begin : r11_busy
            int d0;
            d0 = ndone;
            fork
                run(5, 4'h0, 16'h0, 1'b1, 16'h0, 5, 1'b0);
                begin
                    repeat (6) @(negedge clk);
                    cmd = 3'd3; start = 1'b1;
                    @(negedge clk);
                    start = 1'b0;
                end
            join
            repeat (40) @(negedge clk);
            chk(ndone - d0 == 1 && !busy, "R11 start while busy", 64'(ndone - d0), 64'd1);
        end

        begin : r11_code7
            int r0;
            r0 = rises;
            @(negedge clk);
            cmd = 3'd7; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (10) @(negedge clk);
            chk(!busy && rises == r0, "R11 code 7 ignored", 64'(rises - r0), 64'd0);
        end

        chk(bad_phase == 0, "R5 clock high width", 64'(bad_phase), 64'd0);
        chk(bad_di == 0, "R5 data stable while clock high", 64'(bad_di), 64'd0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule